// File: doc/BRIEF.md
# Banked GPIO Port with Direction and Simple-I/O Enables

This block controls a bank of general-purpose lines. The lines are organised in groups of eight, and every per-group register packs one group's eight lines into one byte. Two separate request ports reach the block. The configuration port holds the per-group direction registers, the per-group simple-I/O enables and the base of the data window. The data port decodes a window of byte registers that starts at that programmable base. A data write loads a group's output latch. A data read returns the live level of each line.

Both ports move data, so each is a request channel and a response channel, both with valid/ready. A request is accepted on a clock edge where `*_req_valid` and `*_req_ready` are both high. Exactly one response follows on the next cycle, and the response stays valid and unchanged until `*_rsp_ready` is high at a clock edge. The block holds one response for each port. While that response is stalled, `*_req_ready` is low, so back-pressure on the response side reaches the requester directly. A write also returns a response, with data zero. The pin vectors have no handshake.

With the defaults there are 64 lines in 8 groups. The first 5 groups have a simple-I/O enable that gates the pad drive, and the data window is 8 bytes long. The parameter GROUPS must be at most 8.

Top module: `gpio_bank`

## Requirements
- R1: Line n is controlled by bit n%8 of the registers that belong to group n/8, and it appears at bit n of `pad_in`, `pad_out` and `pad_oe`.
- R2: The direction register of group g is at configuration offset 0xC8+g and can be read and written. A bit set to 1 selects output and a bit set to 0 selects input.
- R3: The simple-I/O enable of group g is at configuration offset 0xC0+g and exists for g < SIMPLE_GROUPS (5). Offsets 0xC0+SIMPLE_GROUPS through 0xC7 always read 0, and writes to them change nothing.
- R4: The data-window base is at configuration offsets 0x62 (bits 15:8) and 0x63 (bits 7:0) and resets to BASE_RESET. Any configuration offset not named in R2 through R4 reads 0, and writes to it change nothing.
- R5: The data port claims only addresses base through base+GROUPS-1, without wrap-around. The address base+g is the data register of group g, and a write to it loads that group's output latch. For an address outside the window the response has `io_rsp_hit`=0 and data 0, and the request has no effect.
- R6: A data read returns, bit by bit, the output latch for lines whose pad is driven and the pad level, synchronised through SYNC_STAGES flops, for lines that are not driven.
- R7: For groups below SIMPLE_GROUPS, `pad_oe` is the AND of the direction bit and the simple-I/O bit. For the other groups, `pad_oe` equals the direction bit.
- R8: `pad_out` always shows the output latch, whatever the direction. It changes only after an accepted data write.
- R9: Reset clears all direction bits, simple-I/O bits and output latches, so `pad_oe` and `pad_out` are 0.
- R10: A request is accepted when valid and ready are both high, and ready = !rsp_valid || rsp_ready. The response is valid on the cycle after acceptance and holds its data until it is taken. A read response carries the register state at acceptance time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_req_valid | input | 1 | Configuration request valid |
| cfg_req_ready | output | 1 | Configuration request ready |
| cfg_req_write | input | 1 | 1 for a write, 0 for a read |
| cfg_req_addr | input | 8 | Configuration offset |
| cfg_req_wdata | input | 8 | Configuration write data |
| cfg_rsp_valid | output | 1 | Configuration response valid |
| cfg_rsp_ready | input | 1 | Configuration response taken |
| cfg_rsp_rdata | output | 8 | Configuration read data (0 for writes) |
| io_req_valid | input | 1 | Data request valid |
| io_req_ready | output | 1 | Data request ready |
| io_req_write | input | 1 | 1 for a write, 0 for a read |
| io_req_addr | input | 16 | Data port address |
| io_req_wdata | input | 8 | Data write value |
| io_rsp_valid | output | 1 | Data response valid |
| io_rsp_ready | input | 1 | Data response taken |
| io_rsp_rdata | output | 8 | Data read value (0 for writes and misses) |
| io_rsp_hit | output | 1 | 1 when the address fell inside the window |
| pad_in | input | 64 | Pad input levels |
| pad_out | output | 64 | Pad output values |
| pad_oe | output | 64 | Pad output enables |

## Verification
The bench sets a direction bit on a gated group and on an ungated group. A design that ignored the simple-I/O gate, or that applied it to every group, would show the wrong `pad_oe`. It writes the unimplemented simple-I/O offsets and the window edges on both sides. A decoder that is off by one, or that drops the base, would either read a value back or change `pad_out`. Reads of mixed-direction groups expose a design that returns the latch or the pad for every bit. A stalled response checks that ready falls and the data holds, and that a waiting request is accepted only once the response is taken.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BYTE_W = 8;
  localparam int CFG_AW = 8;
  localparam int IO_AW  = 16;
  localparam int SIO_SLOTS = 8;

  localparam logic [CFG_AW-1:0] OFS_DIR     = 8'hC8;
  localparam logic [CFG_AW-1:0] OFS_SIO     = 8'hC0;
  localparam logic [CFG_AW-1:0] OFS_BASE_HI = 8'h62;
  localparam logic [CFG_AW-1:0] OFS_BASE_LO = 8'h63;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_SIO,
    SEL_BHI,
    SEL_BLO
  } cfg_sel_e;
endpackage

// File: rtl/gpio_rsp_slot.sv
module gpio_rsp_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  output logic         accept,
  input  logic [W-1:0] payload,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  // a held response blocks new requests unless it leaves this cycle
  assign req_ready = !full_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= payload;
    end else if (rsp_ready) begin
      full_q <= 1'b0;
    end
  end

  assign rsp_valid = full_q;
  assign rsp_data  = data_q;
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int               GROUPS        = 8,
  parameter int               SIMPLE_GROUPS = 5,
  parameter logic [IO_AW-1:0] BASE_RESET    = '0,
  localparam int              LINES         = GROUPS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  logic [CFG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [LINES-1:0]  dir_q,
  output logic [LINES-1:0]  sio_q,
  output logic [IO_AW-1:0]  base_q
);
  localparam logic [CFG_AW-1:0] GROUPS_B = CFG_AW'(GROUPS);
  localparam logic [CFG_AW-1:0] SLOTS_B  = CFG_AW'(SIO_SLOTS);

  logic [CFG_AW-1:0] dir_idx, sio_idx;
  cfg_sel_e          sel;
  logic              wr_en;

  assign dir_idx = addr - OFS_DIR;
  assign sio_idx = addr - OFS_SIO;
  assign wr_en   = acc && wr;

  always_comb begin
    sel = SEL_NONE;
    if ((addr >= OFS_DIR) && (dir_idx < GROUPS_B))      sel = SEL_DIR;
    else if ((addr >= OFS_SIO) && (sio_idx < SLOTS_B))  sel = SEL_SIO;
    else if (addr == OFS_BASE_HI)                       sel = SEL_BHI;
    else if (addr == OFS_BASE_LO)                       sel = SEL_BLO;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [BYTE_W-1:0] dir_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_r <= '0;
      else if (wr_en && sel == SEL_DIR && dir_idx == CFG_AW'(g)) dir_r <= wdata;
    end
    assign dir_q[g*BYTE_W +: BYTE_W] = dir_r;

    if (g < SIMPLE_GROUPS) begin : g_sio
      logic [BYTE_W-1:0] sio_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sio_r <= '0;
        else if (wr_en && sel == SEL_SIO && sio_idx == CFG_AW'(g)) sio_r <= wdata;
      end
      assign sio_q[g*BYTE_W +: BYTE_W] = sio_r;
    end else begin : g_nosio
      assign sio_q[g*BYTE_W +: BYTE_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BASE_RESET;
    end else if (wr_en) begin
      if (sel == SEL_BHI) base_q[15:8] <= wdata;
      if (sel == SEL_BLO) base_q[7:0]  <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (sel == SEL_DIR && dir_idx == CFG_AW'(g)) rdata = dir_q[g*BYTE_W +: BYTE_W];
      if (sel == SEL_SIO && sio_idx == CFG_AW'(g)) rdata = sio_q[g*BYTE_W +: BYTE_W];
    end
    if (sel == SEL_BHI) rdata = base_q[15:8];
    if (sel == SEL_BLO) rdata = base_q[7:0];
  end
endmodule

// File: rtl/gpio_data_window.sv
module gpio_data_window
  import gpio_bank_pkg::*;
#(
  parameter int  GROUPS = 8,
  localparam int LINES  = GROUPS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  logic [IO_AW-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [IO_AW-1:0]  base,
  input  logic [LINES-1:0]  pin_sync,
  input  logic [LINES-1:0]  drive,
  output logic [LINES-1:0]  latch_q,
  output logic              hit,
  output logic [BYTE_W-1:0] rdata
);
  localparam logic [IO_AW-1:0] GROUPS_W = IO_AW'(GROUPS);

  logic [IO_AW-1:0] off;
  logic [LINES-1:0] merged;

  assign off = addr - base;
  assign hit = (addr >= base) && (off < GROUPS_W);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [BYTE_W-1:0] lat_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_r <= '0;
      else if (acc && wr && hit && off == IO_AW'(g)) lat_r <= wdata;
    end
    assign latch_q[g*BYTE_W +: BYTE_W] = lat_r;
  end

  // driven lines echo the latch, the others show the pad
  assign merged = (latch_q & drive) | (pin_sync & ~drive);

  always_comb begin
    rdata = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (hit && off == IO_AW'(g)) rdata = merged[g*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int               GROUPS        = 8,
  parameter int               SIMPLE_GROUPS = 5,
  parameter int               SYNC_STAGES   = 2,
  parameter logic [IO_AW-1:0] BASE_RESET    = '0,
  localparam int              LINES         = GROUPS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req_valid,
  output logic              cfg_req_ready,
  input  logic              cfg_req_write,
  input  logic [CFG_AW-1:0] cfg_req_addr,
  input  logic [BYTE_W-1:0] cfg_req_wdata,
  output logic              cfg_rsp_valid,
  input  logic              cfg_rsp_ready,
  output logic [BYTE_W-1:0] cfg_rsp_rdata,
  input  logic              io_req_valid,
  output logic              io_req_ready,
  input  logic              io_req_write,
  input  logic [IO_AW-1:0]  io_req_addr,
  input  logic [BYTE_W-1:0] io_req_wdata,
  output logic              io_rsp_valid,
  input  logic              io_rsp_ready,
  output logic [BYTE_W-1:0] io_rsp_rdata,
  output logic              io_rsp_hit,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe
);
  logic              cfg_acc, io_acc;
  logic [BYTE_W-1:0] cfg_rd, io_rd;
  logic              io_hit;
  logic [LINES-1:0]  dir_q, sio_q, pin_sync, latch_q;
  logic [IO_AW-1:0]  base_q;
  logic [BYTE_W-1:0] cfg_payload;
  logic [BYTE_W:0]   io_payload, io_rsp_bits;

  gpio_cfg_regs #(
    .GROUPS(GROUPS), .SIMPLE_GROUPS(SIMPLE_GROUPS), .BASE_RESET(BASE_RESET)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .acc(cfg_acc), .wr(cfg_req_write),
    .addr(cfg_req_addr), .wdata(cfg_req_wdata), .rdata(cfg_rd),
    .dir_q(dir_q), .sio_q(sio_q), .base_q(base_q)
  );

  gpio_pad_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  // drive gating: the simple-I/O bit only exists for the low groups
  for (genvar g = 0; g < GROUPS; g++) begin : g_drive
    if (g < SIMPLE_GROUPS) begin : g_gated
      assign pad_oe[g*BYTE_W +: BYTE_W] =
        dir_q[g*BYTE_W +: BYTE_W] & sio_q[g*BYTE_W +: BYTE_W];
    end else begin : g_plain
      assign pad_oe[g*BYTE_W +: BYTE_W] = dir_q[g*BYTE_W +: BYTE_W];
    end
  end

  gpio_data_window #(.GROUPS(GROUPS)) u_win (
    .clk(clk), .rst_n(rst_n), .acc(io_acc), .wr(io_req_write),
    .addr(io_req_addr), .wdata(io_req_wdata), .base(base_q),
    .pin_sync(pin_sync), .drive(pad_oe), .latch_q(latch_q),
    .hit(io_hit), .rdata(io_rd)
  );

  assign pad_out = latch_q;

  assign cfg_payload = cfg_req_write ? '0 : cfg_rd;
  assign io_payload  = {io_hit, (io_req_write ? 8'h00 : io_rd)};

  gpio_rsp_slot #(.W(BYTE_W)) u_cfg_slot (
    .clk(clk), .rst_n(rst_n), .req_valid(cfg_req_valid), .req_ready(cfg_req_ready),
    .accept(cfg_acc), .payload(cfg_payload), .rsp_valid(cfg_rsp_valid),
    .rsp_ready(cfg_rsp_ready), .rsp_data(cfg_rsp_rdata)
  );

  gpio_rsp_slot #(.W(BYTE_W+1)) u_io_slot (
    .clk(clk), .rst_n(rst_n), .req_valid(io_req_valid), .req_ready(io_req_ready),
    .accept(io_acc), .payload(io_payload), .rsp_valid(io_rsp_valid),
    .rsp_ready(io_rsp_ready), .rsp_data(io_rsp_bits)
  );

  assign io_rsp_hit   = io_rsp_bits[BYTE_W];
  assign io_rsp_rdata = io_rsp_bits[BYTE_W-1:0];
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
  parameter int LINES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_req_valid,
  input logic             cfg_req_ready,
  input logic             cfg_req_write,
  input logic             cfg_rsp_valid,
  input logic             cfg_rsp_ready,
  input logic [7:0]       cfg_rsp_rdata,
  input logic             io_req_valid,
  input logic             io_req_ready,
  input logic             io_req_write,
  input logic             io_rsp_valid,
  input logic             io_rsp_ready,
  input logic [7:0]       io_rsp_rdata,
  input logic             io_rsp_hit,
  input logic [LINES-1:0] pad_out,
  input logic [LINES-1:0] pad_oe
);
  assert_cfg_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rsp_valid && !cfg_rsp_ready |=> cfg_rsp_valid && $stable(cfg_rsp_rdata));

  assert_io_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    io_rsp_valid && !io_rsp_ready |=> io_rsp_valid && $stable(io_rsp_rdata) && $stable(io_rsp_hit));

  assert_cfg_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rsp_valid && !cfg_rsp_ready |-> !cfg_req_ready);

  assert_io_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    io_rsp_valid && !io_rsp_ready |-> !io_req_ready);

  assert_out_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req_valid && io_req_ready && io_req_write) |=> $stable(pad_out));

  assert_oe_needs_cfg_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req_valid && cfg_req_ready && cfg_req_write) |=> $stable(pad_oe));

  assert_miss_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    io_rsp_valid && !io_rsp_hit |-> io_rsp_rdata == 8'h00);

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> pad_oe == '0 && pad_out == '0);
endmodule

bind gpio_bank gpio_bank_checker #(.LINES(LINES)) u_chk (.*);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_req_valid = 1'b0, cfg_req_write = 1'b0, cfg_rsp_ready = 1'b1;
  logic [7:0]  cfg_req_addr = '0, cfg_req_wdata = '0;
  logic        cfg_req_ready, cfg_rsp_valid;
  logic [7:0]  cfg_rsp_rdata;
  logic        io_req_valid = 1'b0, io_req_write = 1'b0, io_rsp_ready = 1'b1;
  logic [15:0] io_req_addr = '0;
  logic [7:0]  io_req_wdata = '0;
  logic        io_req_ready, io_rsp_valid, io_rsp_hit;
  logic [7:0]  io_rsp_rdata;
  logic [63:0] pad_in = '0;
  logic [63:0] pad_out, pad_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_bank u_dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_xfer(input logic wr, input logic [7:0] a, input logic [7:0] wd,
                          output logic [7:0] rd);
    @(negedge clk);
    cfg_req_valid = 1'b1; cfg_req_write = wr; cfg_req_addr = a; cfg_req_wdata = wd;
    while (!cfg_req_ready) @(negedge clk);
    @(negedge clk);
    cfg_req_valid = 1'b0;
    chk("R10 cfg response valid", 64'(cfg_rsp_valid), 64'd1);
    rd = cfg_rsp_rdata;
  endtask

  task automatic io_xfer(input logic wr, input logic [15:0] a, input logic [7:0] wd,
                         output logic [7:0] rd, output logic hit);
    @(negedge clk);
    io_req_valid = 1'b1; io_req_write = wr; io_req_addr = a; io_req_wdata = wd;
    while (!io_req_ready) @(negedge clk);
    @(negedge clk);
    io_req_valid = 1'b0;
    rd = io_rsp_rdata;
    hit = io_rsp_hit;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R9 pad_oe after reset", pad_oe, 64'h0);
    chk("R9 pad_out after reset", pad_out, 64'h0);
    cfg_xfer(1'b0, 8'hC8, 8'h00, d); chk("R9 dir g0 reset", 64'(d), 64'h0);
    cfg_xfer(1'b0, 8'hC0, 8'h00, d); chk("R9 sio g0 reset", 64'(d), 64'h0);
    cfg_xfer(1'b0, 8'h62, 8'h00, d); chk("R4 base high reset", 64'(d), 64'h0);
  endtask

  task automatic t_map;
    logic [7:0] d; logic h;
    cfg_xfer(1'b1, 8'h62, 8'h0A, d);
    cfg_xfer(1'b1, 8'h63, 8'h20, d);
    cfg_xfer(1'b0, 8'h63, 8'h00, d); chk("R4 base low readback", 64'(d), 64'h20);
    io_xfer(1'b1, 16'h0A25, 8'hA5, d, h);
    chk("R5 write hit", 64'(h), 64'd1);
    chk("R1 group5 latch lands in byte5", pad_out, 64'h0000_A500_0000_0000);
    cfg_xfer(1'b1, 8'hCD, 8'hF0, d);
    chk("R7 ungated group drives from dir", pad_oe, 64'h0000_F000_0000_0000);
    cfg_xfer(1'b0, 8'hCD, 8'h00, d); chk("R2 dir g5 readback", 64'(d), 64'hF0);
  endtask

  task automatic t_gate;
    logic [7:0] d;
    cfg_xfer(1'b1, 8'hC9, 8'hFF, d);
    chk("R7 gated group without sio stays off", pad_oe, 64'h0000_F000_0000_0000);
    cfg_xfer(1'b1, 8'hC1, 8'h0F, d);
    chk("R7 gated group with sio", pad_oe, 64'h0000_F000_0000_0F00);
    cfg_xfer(1'b0, 8'hC1, 8'h00, d); chk("R3 sio g1 readback", 64'(d), 64'h0F);
  endtask

  task automatic t_missing;
    logic [7:0] d;
    cfg_xfer(1'b1, 8'hC5, 8'hFF, d);
    cfg_xfer(1'b0, 8'hC5, 8'h00, d); chk("R3 sio g5 absent reads 0", 64'(d), 64'h0);
    chk("R3 absent sio write leaves pad_oe", pad_oe, 64'h0000_F000_0000_0F00);
    cfg_xfer(1'b1, 8'h10, 8'hAB, d);
    cfg_xfer(1'b0, 8'h10, 8'h00, d); chk("R4 unmapped offset reads 0", 64'(d), 64'h0);
    cfg_xfer(1'b0, 8'hC7, 8'h00, d); chk("R3 sio g7 absent reads 0", 64'(d), 64'h0);
  endtask

  task automatic t_readback;
    logic [7:0] d; logic h;
    io_xfer(1'b1, 16'h0A21, 8'h55, d, h);
    pad_in = 64'h0000_3C00_0000_F000;
    repeat (4) @(negedge clk);
    io_xfer(1'b0, 16'h0A25, 8'h00, d, h);
    chk("R6 group5 mixed read", 64'(d), 64'hAC);
    chk("R5 read hit", 64'(h), 64'd1);
    io_xfer(1'b0, 16'h0A21, 8'h00, d, h);
    chk("R6 group1 gated mixed read", 64'(d), 64'hF5);
  endtask

  task automatic t_edges;
    logic [7:0] d; logic h;
    io_xfer(1'b1, 16'h0A28, 8'hFF, d, h);
    chk("R5 past-end miss flag", 64'(h), 64'd0);
    chk("R5 past-end write ignored", pad_out, 64'h0000_A500_0000_5500);
    io_xfer(1'b0, 16'h0A1F, 8'h00, d, h);
    chk("R5 below-base miss", {55'd0, h, d}, 64'h0);
    io_xfer(1'b1, 16'h0A27, 8'h81, d, h);
    chk("R5 last group write", pad_out, 64'h8100_A500_0000_5500);
    io_xfer(1'b0, 16'h0A27, 8'h00, d, h);
    chk("R6 input line shows pad not latch", 64'(d), 64'h00);
  endtask

  task automatic t_latch_input;
    logic [7:0] d; logic h;
    io_xfer(1'b1, 16'h0A20, 8'h77, d, h);
    chk("R8 latch visible on input line", pad_out, 64'h8100_A500_0000_5577);
    chk("R8 input line not driven", pad_oe[7:0], 64'h0);
  endtask

  task automatic t_relocate;
    logic [7:0] d; logic h;
    cfg_xfer(1'b1, 8'h62, 8'h03, d);
    cfg_xfer(1'b1, 8'h63, 8'h00, d);
    io_xfer(1'b0, 16'h0305, 8'h00, d, h);
    chk("R5 relocated window read", {55'd0, h, d}, {55'd0, 1'b1, 8'hAC});
    io_xfer(1'b0, 16'h0A25, 8'h00, d, h);
    chk("R5 old window no longer claimed", 64'(h), 64'd0);
  endtask

  task automatic t_backpressure;
    cfg_rsp_ready = 1'b0;
    @(negedge clk);
    cfg_req_valid = 1'b1; cfg_req_write = 1'b0; cfg_req_addr = 8'hC9;
    @(negedge clk);
    cfg_req_addr = 8'hC1;
    repeat (3) @(negedge clk);
    chk("R10 stalled response valid", 64'(cfg_rsp_valid), 64'd1);
    chk("R10 stalled response data", 64'(cfg_rsp_rdata), 64'hFF);
    chk("R10 ready low while stalled", 64'(cfg_req_ready), 64'd0);
    cfg_rsp_ready = 1'b1;
    @(negedge clk);
    cfg_req_valid = 1'b0;
    chk("R10 waiting request served after release", 64'(cfg_rsp_rdata), 64'h0F);
    @(negedge clk);
    chk("R10 response drained", 64'(cfg_rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_map;
    t_gate;
    t_missing;
    t_readback;
    t_edges;
    t_latch_input;
    t_relocate;
    t_backpressure;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule